// File: doc/BRIEF.md
# Programmable Sum-of-Products Array

This block is the logic core of a small programmable logic cell. Twenty input signals enter a buffer stage that produces a true line and an inverted line for each, giving forty array columns. Sixty-four product-term rows each choose any subset of those columns through a per-row connection mask. A row is the AND of its connected columns. Rows are split into eight groups of eight, and each group feeds a fixed OR that gives one sum output.

The connection masks sit in flip-flops and are written one row at a time through a simple write port. Every individual term is also exported, and each group's first term appears on its own output, so a downstream cell can use that term for another purpose, such as an output enable. A mode input marks the surrounding device as registered. In that mode the two inputs that double as clock and enable are kept out of the array.

Top module: `sop_array`

## Requirements
- R1: While reset (`rst_ni` low, asynchronous) is asserted, and after it is released, every connection mask is all zero, so all 64 `term_o` bits, all 8 `sum_o` bits and all 8 `first_term_o` bits read 1.
- R2: Mask bit 2*i connects the true line of `in_i[i]`, and mask bit 2*i+1 connects its complement. A row's term is the AND of its connected columns.
- R3: A row that connects both the true and the complement column of the same input (not gated by R8) reads 0 for every input pattern.
- R4: A row whose mask is all zero reads 1.
- R5: When `cfg_we_i` is high at a rising clock edge, row `cfg_addr_i` takes `cfg_data_i`, and the outputs reflect it combinationally from that edge on. Other rows are unchanged. With `cfg_we_i` low, nothing is written.
- R6: `sum_o[g]` is the OR of term rows 8*g through 8*g+7.
- R7: `first_term_o[g]` equals term row 8*g.
- R8: When `reg_mode_i` is 1, both columns of input 0 and both columns of input 11 read 1, so connections to them have no effect. When `reg_mode_i` is 0, those inputs behave like the others.
- R9: `term_o[r]` is the term of row r, for all 64 rows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the configuration registers |
| rst_ni | input | 1 | Active-low asynchronous reset, clears all masks |
| reg_mode_i | input | 1 | 1 = registered device; input 0 and input 11 are kept out of the array |
| in_i | input | 20 | Array input signals |
| cfg_we_i | input | 1 | Row write strobe |
| cfg_addr_i | input | 6 | Row index to write |
| cfg_data_i | input | 40 | Connection mask for the addressed row |
| term_o | output | 64 | Every product term, row r on bit r |
| sum_o | output | 8 | OR of each group of eight terms |
| first_term_o | output | 8 | First term of each group |

## Verification
The bench fills most of group 0 with rows that connect both polarities of input 1. It then drives row 0 low, which checks that the group OR really falls to 0. A design that tied unused or conflicting rows high would keep the sum stuck at 1. Conflicting masks on input 0 and input 11 are applied in both modes. A design that gated those inputs to 0, or gated them in the wrong mode, would force terms low where they should stay high. Row 63, the top-column bit 39, masks written with the strobe low, and a mid-run reset are all checked. These catch an addressing slip, a misplaced polarity bit, a write that ignores the strobe, and a reset that leaves stale connections.

// File: rtl/sop_pkg.sv
package sop_pkg;
  parameter int N_IN_DEF   = 20;
  parameter int GROUPS_DEF = 8;
  parameter int TPG_DEF    = 8;
  parameter int CLK_IDX_DEF = 0;
  parameter int OE_IDX_DEF  = 11;
endpackage

// File: rtl/sop_in_buf.sv
module sop_in_buf #(
  parameter int N_IN    = 20,
  parameter int CLK_IDX = 0,
  parameter int OE_IDX  = 11,
  localparam int COLS   = 2 * N_IN
) (
  input  logic [N_IN-1:0] in_i,
  input  logic            reg_mode_i,
  output logic [COLS-1:0] cols_o
);
  for (genvar i = 0; i < N_IN; i++) begin : g_buf
    if (i == CLK_IDX || i == OE_IDX) begin : g_shared
      // shared-function pin: both lines pinned high in registered mode
      assign cols_o[2*i]   = reg_mode_i |  in_i[i];
      assign cols_o[2*i+1] = reg_mode_i | ~in_i[i];
    end else begin : g_plain
      assign cols_o[2*i]   =  in_i[i];
      assign cols_o[2*i+1] = ~in_i[i];
    end
  end
endmodule

// File: rtl/sop_conn_map.sv
module sop_conn_map #(
  parameter int COLS   = 40,
  parameter int ROWS   = 64,
  parameter int ADDR_W = 6
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      we_i,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic [COLS-1:0]           data_i,
  output logic [ROWS-1:0][COLS-1:0] map_o
);
  for (genvar r = 0; r < ROWS; r++) begin : g_row
    logic sel;
    assign sel = we_i && (addr_i == ADDR_W'(r));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  map_o[r] <= '0;
      else if (sel) map_o[r] <= data_i;
    end
  end
endmodule

// File: rtl/sop_term_row.sv
module sop_term_row #(
  parameter int COLS = 40
) (
  input  logic [COLS-1:0] cols_i,
  input  logic [COLS-1:0] conn_i,
  output logic            term_o
);
  // open connection contributes 1; empty row therefore reads 1
  assign term_o = &(~conn_i | cols_i);
endmodule

// File: rtl/sop_or_group.sv
module sop_or_group #(
  parameter int TPG = 8
) (
  input  logic [TPG-1:0] terms_i,
  output logic           sum_o,
  output logic           first_o
);
  assign sum_o   = |terms_i;
  assign first_o = terms_i[0];
endmodule

// File: rtl/sop_array.sv
module sop_array
  import sop_pkg::*;
#(
  parameter int N_IN    = N_IN_DEF,
  parameter int GROUPS  = GROUPS_DEF,
  parameter int TPG     = TPG_DEF,
  parameter int CLK_IDX = CLK_IDX_DEF,
  parameter int OE_IDX  = OE_IDX_DEF,
  localparam int COLS   = 2 * N_IN,
  localparam int ROWS   = GROUPS * TPG,
  localparam int ADDR_W = $clog2(ROWS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_mode_i,
  input  logic [N_IN-1:0]   in_i,
  input  logic              cfg_we_i,
  input  logic [ADDR_W-1:0] cfg_addr_i,
  input  logic [COLS-1:0]   cfg_data_i,
  output logic [ROWS-1:0]   term_o,
  output logic [GROUPS-1:0] sum_o,
  output logic [GROUPS-1:0] first_term_o
);
  logic [COLS-1:0]           cols;
  logic [ROWS-1:0][COLS-1:0] conn_map;

  sop_in_buf #(.N_IN(N_IN), .CLK_IDX(CLK_IDX), .OE_IDX(OE_IDX)) u_in_buf (
    .in_i      (in_i),
    .reg_mode_i(reg_mode_i),
    .cols_o    (cols)
  );

  sop_conn_map #(.COLS(COLS), .ROWS(ROWS), .ADDR_W(ADDR_W)) u_map (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .we_i  (cfg_we_i),
    .addr_i(cfg_addr_i),
    .data_i(cfg_data_i),
    .map_o (conn_map)
  );

  for (genvar r = 0; r < ROWS; r++) begin : g_term
    sop_term_row #(.COLS(COLS)) u_row (
      .cols_i(cols),
      .conn_i(conn_map[r]),
      .term_o(term_o[r])
    );
  end

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    sop_or_group #(.TPG(TPG)) u_grp (
      .terms_i(term_o[g*TPG +: TPG]),
      .sum_o  (sum_o[g]),
      .first_o(first_term_o[g])
    );
  end
endmodule

// File: rtl/sop_array_chk.sv
module sop_array_chk #(
  parameter int COLS   = 40,
  parameter int ROWS   = 64,
  parameter int GROUPS = 8,
  parameter int TPG    = 8,
  parameter int ADDR_W = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cfg_we_i,
  input logic [ADDR_W-1:0] cfg_addr_i,
  input logic [COLS-1:0]   cfg_data_i,
  input logic [ROWS-1:0]   term_o,
  input logic [GROUPS-1:0] sum_o,
  input logic [GROUPS-1:0] first_term_o
);
  // R3: both polarities of input 1 force the written row low
  a_r3_conflict_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && cfg_data_i[3:2] == 2'b11) |=> !term_o[$past(cfg_addr_i)]);

  // R4 / R5: an empty mask written to a row reads high next cycle
  a_r4_empty_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && cfg_data_i == '0) |=> term_o[$past(cfg_addr_i)]);

  for (genvar g = 0; g < GROUPS; g++) begin : g_chk
    // R6
    a_r6_group_or: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sum_o[g] == (|term_o[g*TPG +: TPG]));
    // R7
    a_r7_first_term: assert property (@(posedge clk_i) disable iff (!rst_ni)
      first_term_o[g] == term_o[g*TPG]);
  end
endmodule

bind sop_array sop_array_chk #(
  .COLS(COLS), .ROWS(ROWS), .GROUPS(GROUPS), .TPG(TPG), .ADDR_W(ADDR_W)
) u_chk (.*);

// File: tb/tb_sop_array.sv
module tb_sop_array;
  localparam int N_IN = 20;
  localparam int COLS = 40;
  localparam int ROWS = 64;
  localparam int GROUPS = 8;
  localparam int TPG = 8;
  localparam int NV = 20;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic reg_mode_i = 1'b0;
  logic [N_IN-1:0] in_i = '0;
  logic cfg_we_i = 1'b0;
  logic [5:0] cfg_addr_i = '0;
  logic [COLS-1:0] cfg_data_i = '0;
  logic [ROWS-1:0] term_o;
  logic [GROUPS-1:0] sum_o;
  logic [GROUPS-1:0] first_term_o;

  int n_vec = 0;
  int n_bad = 0;
  logic [COLS-1:0] shadow [ROWS];

  sop_array dut (.*);

  always #4 clk_i = ~clk_i;

  // {addr, mask, inputs, reg_mode}
  localparam logic [66:0] VEC [NV] = '{
    {6'd1,  40'h000000000C, 20'h00000, 1'b0},  // R3 rows 1..7 conflict on input 1
    {6'd2,  40'h000000000C, 20'h00000, 1'b0},
    {6'd3,  40'h000000000C, 20'h00000, 1'b0},
    {6'd4,  40'h000000000C, 20'h00000, 1'b0},
    {6'd5,  40'h000000000C, 20'hFFFFF, 1'b0},
    {6'd6,  40'h000000000C, 20'h00000, 1'b0},
    {6'd7,  40'h000000000C, 20'h00002, 1'b0},
    {6'd0,  40'h0000000004, 20'h00002, 1'b0},  // R2 true line, high
    {6'd0,  40'h0000000004, 20'h00000, 1'b0},  // R6 whole group low
    {6'd0,  40'h0000000008, 20'h00000, 1'b0},  // R2 complement line
    {6'd8,  40'h8000000000, 20'h80000, 1'b0},  // R2 top column bit 39
    {6'd0,  40'h0000000003, 20'h00000, 1'b0},  // R3 input 0 conflict
    {6'd0,  40'h0000000003, 20'h00001, 1'b1},  // R8 input 0 gated
    {6'd0,  40'h0000C00000, 20'h00000, 1'b1},  // R8 input 11 gated
    {6'd0,  40'h0000C00000, 20'h00000, 1'b0},  // R3 input 11 conflict
    {6'd0,  40'h0000400000, 20'h00000, 1'b1},  // R8 true line of 11 ignored
    {6'd0,  40'h0000400000, 20'h00000, 1'b0},  // R2 true line of 11 low
    {6'd63, 40'hAAAAAAAAAA, 20'h00000, 1'b0},  // R9 row 63 all complements
    {6'd63, 40'h5555555555, 20'hFFFFF, 1'b0},  // R9 row 63 all true
    {6'd1,  40'h0000000000, 20'h00000, 1'b0}   // R4 empty row high
  };

  function automatic logic exp_term(int r);
    logic t, c, v;
    v = 1'b1;
    for (int i = 0; i < N_IN; i++) begin
      t = in_i[i];
      c = ~in_i[i];
      if (reg_mode_i && (i == 0 || i == 11)) begin
        t = 1'b1;
        c = 1'b1;
      end
      if (shadow[r][2*i] && !t) v = 1'b0;
      if (shadow[r][2*i+1] && !c) v = 1'b0;
    end
    return v;
  endfunction

  task automatic check_all(string tag);
    logic [ROWS-1:0] et;
    logic [GROUPS-1:0] es, ef;
    for (int r = 0; r < ROWS; r++) et[r] = exp_term(r);
    for (int g = 0; g < GROUPS; g++) begin
      es[g] = |et[g*TPG +: TPG];
      ef[g] = et[g*TPG];
    end
    n_vec++;
    if (term_o !== et || sum_o !== es || first_term_o !== ef) begin
      n_bad++;
      $display("FAIL %s: term=%h sum=%h first=%h expected term=%h sum=%h first=%h",
               tag, term_o, sum_o, first_term_o, et, es, ef);
    end
  endtask

  task automatic write_row(logic [5:0] a, logic [COLS-1:0] d, logic we);
    @(negedge clk_i);
    cfg_we_i   = we;
    cfg_addr_i = a;
    cfg_data_i = d;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
    if (we) shadow[a] = d;
  endtask

  initial begin
    for (int r = 0; r < ROWS; r++) shadow[r] = '0;
    #1;
    repeat (2) @(negedge clk_i);
    check_all("R1 during reset");
    rst_ni = 1'b1;
    @(negedge clk_i);
    #1 check_all("R1 after reset");

    for (int v = 0; v < NV; v++) begin
      in_i = VEC[v][20:1];
      reg_mode_i = VEC[v][0];
      write_row(VEC[v][66:61], VEC[v][60:21], 1'b1);
      #1 check_all($sformatf("R2/R3/R4/R5/R6/R7/R8/R9 vector %0d", v));
    end

    // R5: strobe low, row 2 keeps its conflicting mask
    in_i = 20'h00000;
    reg_mode_i = 1'b0;
    write_row(6'd2, 40'h0000000000, 1'b0);
    #1 check_all("R5 write ignored without strobe");

    // R5: write to row 9 leaves row 8 and the rest alone
    in_i = 20'h80000;
    write_row(6'd9, 40'h000000000C, 1'b1);
    #1 check_all("R5 neighbour untouched");

    // R1: reset mid-run clears every mask
    @(negedge clk_i);
    rst_ni = 1'b0;
    for (int r = 0; r < ROWS; r++) shadow[r] = '0;
    #1 check_all("R1 mid-run reset");
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    #1 check_all("R1 released after mid-run reset");

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog: run did not complete, actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule